// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block converts a 32-bit virtual address into a 34-bit physical address. It reads page-table entries from memory through a request/response port. The walk starts from a root table page supplied by the caller. Each entry is either a pointer to a table at the next level or a leaf that grants permissions. A leaf found at the upper level maps a 4 MiB region, and a leaf at the lower level maps a 4 KiB page.

The caller presents one request carrying:
- the virtual address,
- the access kind: instruction fetch, load, store or atomic read-modify-write,
- the privilege (user or supervisor),
- the supervisor-may-touch-user-pages bit,
- the make-executable-readable bit.

The walker answers with one response. The response carries either the translated address and the leaf level, or a page-fault or access-fault code.

When a leaf's accessed or dirty flag must be raised, a build-time parameter picks one of two behaviours:
- The walker writes the entry back while holding a memory lock that spans the read and the write.
- The walker reports a page fault instead.

An error response from memory to any entry read or write becomes an access fault.

Top module: `pt_walk`

## Requirements
- R1: While reset is low and right after it: `req_ready_o`=1, `rsp_valid_o`=0, `mem_req_valid_o`=0, `mem_lock_o`=0.
- R2: The first entry read goes to `{root_ppn_i, va[31:22], 2'b00}`. After a pointer entry, the next read goes to `{entry[31:10], va[21:12], 2'b00}`. Entry bits are: 0 valid, 1 read, 2 write, 3 execute, 4 user, 5 global, 6 accessed, 7 dirty, 8-9 software-owned (ignored), 31:10 page number.
- R3: An entry with valid=0, or with read=0 and write=1, ends the walk with `rsp_fault_o`=1 (page fault). No further read is issued. Fault codes: 0 none, 1 page, 2 access.
- R4: A pointer entry (valid=1, read=0, execute=0) found at the lower level gives a page fault.
- R5: Access kinds are 0 fetch, 1 load, 2 store, 3 atomic. A leaf is permitted only under both of these rules, otherwise a page fault results:
  - By access kind: a fetch needs execute; a load needs read, or execute together with `req_mxr_i`; a store or atomic needs write.
  - By privilege: in user mode (`req_user_i`=1) the leaf needs user=1. In supervisor mode a user=1 leaf is allowed only when `req_sum_i`=1 and the access is not a fetch.
- R6: A leaf at the upper level with a nonzero `entry[19:10]` gives a page fault.
- R7: On success `rsp_fault_o`=0.
  - For a lower-level leaf, `rsp_paddr_o` = `{entry[31:10], va[11:0]}` and `rsp_mega_o`=0.
  - For an upper-level leaf, `rsp_paddr_o` = `{entry[31:20], va[21:0]}` and `rsp_mega_o`=1.
- R8: With `AD_UPDATE`=1, a permitted leaf whose accessed bit is 0, or whose dirty bit is 0 on a store or atomic, is written back to the same address. The written word has bit 6 set, also bit 7 for a store or atomic, and all other bits unchanged. `mem_lock_o` stays high from the entry read through the write. No write occurs when the bits already suffice.
- R9: With `AD_UPDATE`=0, the same leaf condition gives a page fault and no write.
- R10: `mem_rsp_err_i`=1 on an entry read or write gives `rsp_fault_o`=2 (access fault).
- R11: Only one walk is in flight. `req_ready_o` is low from acceptance until the response has been given. `rsp_valid_o` is a one-cycle pulse. `rsp_acc_o` returns the request's access kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vaddr_i | input | 32 | Virtual address |
| req_acc_i | input | 2 | Access kind (0 fetch, 1 load, 2 store, 3 atomic) |
| req_user_i | input | 1 | 1 = user privilege, 0 = supervisor |
| req_sum_i | input | 1 | Supervisor may access user pages |
| req_mxr_i | input | 1 | Executable pages readable by loads |
| root_ppn_i | input | 22 | Page number of the root table |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_addr_o | output | 34 | Entry address |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_wdata_o | output | 32 | Entry write data |
| mem_lock_o | output | 1 | Hold off other accesses to the entry |
| mem_rsp_valid_i | input | 1 | Memory response valid |
| mem_rsp_data_i | input | 32 | Read data |
| mem_rsp_err_i | input | 1 | Access error on this request |
| rsp_valid_o | output | 1 | Walk result valid (one cycle) |
| rsp_paddr_o | output | 34 | Physical address |
| rsp_mega_o | output | 1 | Leaf found at the upper level |
| rsp_fault_o | output | 2 | 0 none, 1 page, 2 access |
| rsp_acc_o | output | 2 | Access kind of this walk |

## Verification
The assertions assume that memory returns exactly one response for each accepted request, always after the acceptance cycle. They also assume that memory never responds while no request is outstanding.

The bench memory model follows this rule. It answers one cycle after each handshake, and it stalls `mem_req_ready_i` on a fixed pattern so that request-hold behaviour is exercised. Requests are raised only while `req_ready_o` is high.

Two walkers, one per update mode, see identical stimulus. The bench sweeps every combination of permission bits, access kind, privilege, SUM and MXR, and every accessed/dirty case.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = 10;
  localparam int PPN_W = 22;
  localparam int PTE_W = 32;
  localparam int PA_W  = PPN_W + OFF_W;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_AMO   = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_PAGE   = 2'd1,
    FLT_ACCESS = 2'd2
  } flt_e;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic [1:0]       sw;
    logic             d;
    logic             a;
    logic             g;
    logic             u;
    logic             x;
    logic             w;
    logic             r;
    logic             v;
  } pte_t;
endpackage

// File: rtl/pt_walk_pte_eval.sv
module pt_walk_pte_eval
  import pt_walk_pkg::*;
(
  input  pte_t pte_i,
  input  logic upper_i,
  input  acc_e acc_i,
  input  logic user_i,
  input  logic sum_i,
  input  logic mxr_i,
  output logic next_o,
  output logic pf_o,
  output logic upd_o,
  output pte_t wb_o
);
  logic bad, ptr, leaf, perm, priv_ok, mis, wr_kind, need;

  always_comb begin
    bad  = !pte_i.v || (!pte_i.r && pte_i.w);
    ptr  = !bad && !pte_i.r && !pte_i.x;
    leaf = !bad && !ptr;
    unique case (acc_i)
      ACC_FETCH: perm = pte_i.x;
      ACC_LOAD:  perm = pte_i.r || (mxr_i && pte_i.x);
      default:   perm = pte_i.w;
    endcase
    priv_ok = user_i ? pte_i.u : (!pte_i.u || (sum_i && acc_i != ACC_FETCH));
    mis     = upper_i && (|pte_i.ppn[VPN_W-1:0]);
    wr_kind = (acc_i == ACC_STORE) || (acc_i == ACC_AMO);
    need    = !pte_i.a || (wr_kind && !pte_i.d);
    next_o  = ptr && upper_i;
    pf_o    = bad || (ptr && !upper_i) || (leaf && (!perm || !priv_ok || mis));
    upd_o   = leaf && !pf_o && need;
    wb_o    = pte_i;
    wb_o.a  = 1'b1;
    if (wr_kind) wb_o.d = 1'b1;
  end
endmodule

// File: rtl/pt_walk_addr.sv
module pt_walk_addr
  import pt_walk_pkg::*;
(
  input  logic [PPN_W-1:0] base_ppn_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic             upper_i,
  input  logic [PPN_W-1:0] leaf_ppn_i,
  output logic [PA_W-1:0]  pte_addr_o,
  output logic [PA_W-1:0]  paddr_o
);
  localparam int IDX_LSB = OFF_W - VPN_W;
  localparam int HI_LSB  = OFF_W + VPN_W;

  logic [VPN_W-1:0] vpn_sel;

  always_comb begin
    vpn_sel    = upper_i ? va_i[VA_W-1:HI_LSB] : va_i[HI_LSB-1:OFF_W];
    pte_addr_o = {base_ppn_i, vpn_sel, {IDX_LSB{1'b0}}};
    paddr_o    = upper_i ? {leaf_ppn_i[PPN_W-1:VPN_W], va_i[HI_LSB-1:0]}
                         : {leaf_ppn_i, va_i[OFF_W-1:0]};
  end
endmodule

// File: rtl/pt_walk.sv
module pt_walk
  import pt_walk_pkg::*;
#(
  parameter bit AD_UPDATE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [1:0]       req_acc_i,
  input  logic             req_user_i,
  input  logic             req_sum_i,
  input  logic             req_mxr_i,
  input  logic [PPN_W-1:0] root_ppn_i,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic             mem_we_o,
  output logic [PTE_W-1:0] mem_wdata_o,
  output logic             mem_lock_o,
  input  logic             mem_rsp_valid_i,
  input  logic [PTE_W-1:0] mem_rsp_data_i,
  input  logic             mem_rsp_err_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_mega_o,
  output logic [1:0]       rsp_fault_o,
  output logic [1:0]       rsp_acc_o
);
  typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_RD_W, ST_WB, ST_WB_W, ST_DONE} st_e;

  st_e              state_q;
  logic [VA_W-1:0]  va_q;
  acc_e             acc_q;
  logic             user_q, sum_q, mxr_q, upper_q, mega_q;
  logic [PPN_W-1:0] base_q;
  logic [PA_W-1:0]  paddr_q;
  pte_t             wb_q;
  flt_e             flt_q;

  pte_t             rsp_pte, wb_pte;
  logic             pte_next, pte_pf, pte_upd;
  logic [PA_W-1:0]  pte_addr, leaf_pa;

  assign rsp_pte = pte_t'(mem_rsp_data_i);

  pt_walk_pte_eval u_eval (
    .pte_i   (rsp_pte),
    .upper_i (upper_q),
    .acc_i   (acc_q),
    .user_i  (user_q),
    .sum_i   (sum_q),
    .mxr_i   (mxr_q),
    .next_o  (pte_next),
    .pf_o    (pte_pf),
    .upd_o   (pte_upd),
    .wb_o    (wb_pte)
  );

  pt_walk_addr u_addr (
    .base_ppn_i (base_q),
    .va_i       (va_q),
    .upper_i    (upper_q),
    .leaf_ppn_i (rsp_pte.ppn),
    .pte_addr_o (pte_addr),
    .paddr_o    (leaf_pa)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      acc_q   <= ACC_FETCH;
      user_q  <= 1'b0;
      sum_q   <= 1'b0;
      mxr_q   <= 1'b0;
      upper_q <= 1'b1;
      mega_q  <= 1'b0;
      base_q  <= '0;
      paddr_q <= '0;
      wb_q    <= '0;
      flt_q   <= FLT_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q    <= req_vaddr_i;
          acc_q   <= acc_e'(req_acc_i);
          user_q  <= req_user_i;
          sum_q   <= req_sum_i;
          mxr_q   <= req_mxr_i;
          base_q  <= root_ppn_i;
          upper_q <= 1'b1;
          state_q <= ST_RD;
        end
        ST_RD: if (mem_req_ready_i) state_q <= ST_RD_W;
        ST_RD_W: if (mem_rsp_valid_i) begin
          paddr_q <= leaf_pa;
          mega_q  <= upper_q;
          if (mem_rsp_err_i) begin
            flt_q   <= FLT_ACCESS;
            state_q <= ST_DONE;
          end else if (pte_pf) begin
            flt_q   <= FLT_PAGE;
            state_q <= ST_DONE;
          end else if (pte_next) begin
            base_q  <= rsp_pte.ppn;
            upper_q <= 1'b0;
            state_q <= ST_RD;
          end else if (pte_upd) begin
            if (AD_UPDATE) begin
              wb_q    <= wb_pte;
              state_q <= ST_WB;
            end else begin
              flt_q   <= FLT_PAGE;
              state_q <= ST_DONE;
            end
          end else begin
            flt_q   <= FLT_NONE;
            state_q <= ST_DONE;
          end
        end
        ST_WB: if (mem_req_ready_i) state_q <= ST_WB_W;
        ST_WB_W: if (mem_rsp_valid_i) begin
          flt_q   <= mem_rsp_err_i ? FLT_ACCESS : FLT_NONE;
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_RD) || (state_q == ST_WB);
  assign mem_we_o        = (state_q == ST_WB);
  assign mem_addr_o      = pte_addr;
  assign mem_wdata_o     = wb_q;
  assign mem_lock_o      = AD_UPDATE && (state_q inside {ST_RD, ST_RD_W, ST_WB, ST_WB_W});
  assign rsp_valid_o     = (state_q == ST_DONE);
  assign rsp_paddr_o     = paddr_q;
  assign rsp_mega_o      = mega_q;
  assign rsp_fault_o     = flt_q;
  assign rsp_acc_o       = acc_q;

  // R8
  lock_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_we_o) |-> (mem_lock_o && $past(mem_lock_o)));
  // R11
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R11
  busy_no_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o);
  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  // R10
  err_to_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_W && mem_rsp_valid_i && mem_rsp_err_i) |=>
      (rsp_valid_o && rsp_fault_o == FLT_ACCESS));

  if (!AD_UPDATE) begin : g_nowb
    // R9
    no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(mem_req_valid_o && mem_we_o));
  end
endmodule

// File: tb/tb_pt_walk.sv
module tb_pt_walk;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;

  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0, req_sum = 1'b0, req_mxr = 1'b0;
  logic [21:0] root = '0;

  logic        rdy   [2];
  logic        m_vld [2];
  logic        m_rdy;
  logic [33:0] m_addr[2];
  logic        m_we  [2];
  logic [31:0] m_wd  [2];
  logic        m_lock[2];
  logic        m_rv  [2];
  logic [31:0] m_rd  [2];
  logic        m_err [2];
  logic        r_v   [2];
  logic [33:0] r_pa  [2];
  logic        r_mg  [2];
  logic [1:0]  r_flt [2];
  logic [1:0]  r_acc [2];

  logic        done  [2];
  logic [33:0] g_pa  [2];
  logic        g_mg  [2];
  logic [1:0]  g_flt [2];
  logic [1:0]  g_acc [2];
  int          wr_cnt[2], rd_cnt[2], lock_bad[2];
  logic [33:0] rd_a  [2], rd_b[2];
  logic [31:0] mem   [2][4096];

  assign m_rdy = (cyc % 3) != 1;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic mem_err(logic [33:0] a, logic we);
    return (a[33:14] != 0) || (we && a[13:12] == 2'd3);
  endfunction

  for (genvar g = 0; g < 2; g++) begin : u
    pt_walk #(.AD_UPDATE(g == 0 ? 1'b1 : 1'b0)) dut (
      .clk_i(clk), .rst_ni(rst_ni),
      .req_valid_i(req_valid), .req_ready_o(rdy[g]), .req_vaddr_i(req_va),
      .req_acc_i(req_acc), .req_user_i(req_user), .req_sum_i(req_sum),
      .req_mxr_i(req_mxr), .root_ppn_i(root),
      .mem_req_valid_o(m_vld[g]), .mem_req_ready_i(m_rdy), .mem_addr_o(m_addr[g]),
      .mem_we_o(m_we[g]), .mem_wdata_o(m_wd[g]), .mem_lock_o(m_lock[g]),
      .mem_rsp_valid_i(m_rv[g]), .mem_rsp_data_i(m_rd[g]), .mem_rsp_err_i(m_err[g]),
      .rsp_valid_o(r_v[g]), .rsp_paddr_o(r_pa[g]), .rsp_mega_o(r_mg[g]),
      .rsp_fault_o(r_flt[g]), .rsp_acc_o(r_acc[g])
    );

    always @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        m_rv[g]  <= 1'b0;
        m_rd[g]  <= '0;
        m_err[g] <= 1'b0;
      end else begin
        m_rv[g] <= 1'b0;
        if (m_vld[g] && m_rdy) begin
          m_rv[g]  <= 1'b1;
          m_err[g] <= mem_err(m_addr[g], m_we[g]);
          m_rd[g]  <= mem[g][{m_addr[g][13:12], m_addr[g][11:2]}];
          if (m_we[g]) begin
            if (!mem_err(m_addr[g], 1'b1)) mem[g][{m_addr[g][13:12], m_addr[g][11:2]}] <= m_wd[g];
            wr_cnt[g] <= wr_cnt[g] + 1;
            if (!m_lock[g]) lock_bad[g] <= lock_bad[g] + 1;
          end else begin
            if (rd_cnt[g] == 0) rd_a[g] <= m_addr[g];
            else if (rd_cnt[g] == 1) rd_b[g] <= m_addr[g];
            rd_cnt[g] <= rd_cnt[g] + 1;
          end
        end
      end
    end

    always @(posedge clk) begin
      if (r_v[g]) begin
        done[g]  <= 1'b1;
        g_pa[g]  <= r_pa[g];
        g_mg[g]  <= r_mg[g];
        g_flt[g] <= r_flt[g];
        g_acc[g] <= r_acc[g];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_pte(input logic [1:0] pg, input logic [9:0] idx, input logic [31:0] val);
    for (int g = 0; g < 2; g++) mem[g][{pg, idx}] = val;
  endtask

  task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic usr,
                      input logic sum, input logic mxr, input logic [21:0] rp);
    int t;
    @(negedge clk);
    for (int g = 0; g < 2; g++) begin
      done[g] = 1'b0; wr_cnt[g] = 0; rd_cnt[g] = 0; lock_bad[g] = 0;
    end
    req_va = va; req_acc = acc; req_user = usr; req_sum = sum; req_mxr = mxr; root = rp;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    // R11: busy after acceptance
    chk(!rdy[0] && !rdy[1], "R11 ready low while busy", {32'd0, rdy[0], rdy[1]}, 34'd0);
    t = 0;
    while (!(done[0] && done[1]) && t < 300) begin
      @(negedge clk);
      t++;
    end
    chk(t < 300, "R11 walk completes", 34'(t), 34'd300);
    chk(rdy[0] && rdy[1], "R11 ready after response", {32'd0, rdy[0], rdy[1]}, 34'd3);
    for (int g = 0; g < 2; g++)
      chk(g_acc[g] == acc, "R11 access kind echoed", 34'(g_acc[g]), 34'(acc));
  endtask

  // f = {d,a,g,u,x,w,r,v}
  function automatic logic [1:0] exp_flt(logic [7:0] f, logic [1:0] acc, logic usr, logic sum,
                                         logic mxr, logic upper, logic mis, logic upd);
    logic ok, pv;
    if (!f[0] || (!f[1] && f[2])) return 2'd1;
    if (!f[1] && !f[3]) return upper ? 2'd0 : 2'd1;
    case (acc)
      2'd0:    ok = f[3];
      2'd1:    ok = f[1] || (mxr && f[3]);
      default: ok = f[2];
    endcase
    pv = usr ? f[4] : (!f[4] || (sum && acc != 2'd0));
    if (!ok || !pv) return 2'd1;
    if (upper && mis) return 2'd1;
    if ((!f[6] || (acc[1] && !f[7])) && !upd) return 2'd1;
    return 2'd0;
  endfunction

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", wd, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    for (int g = 0; g < 2; g++) begin
      for (int i = 0; i < 4096; i++) mem[g][i] = '0;
      done[g] = 1'b0; wr_cnt[g] = 0; rd_cnt[g] = 0; lock_bad[g] = 0;
    end
    repeat (3) @(negedge clk);
    for (int g = 0; g < 2; g++)
      chk(rdy[g] && !r_v[g] && !m_vld[g] && !m_lock[g], "R1 reset state",
          {30'd0, rdy[g], r_v[g], m_vld[g], m_lock[g]}, 34'h8);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int g = 0; g < 2; g++)
      chk(rdy[g] && !r_v[g] && !m_vld[g] && !m_lock[g], "R1 after reset",
          {30'd0, rdy[g], r_v[g], m_vld[g], m_lock[g]}, 34'h8);

    // R3 R4 R5 R7 R2: sweep permissions, kinds, privilege, SUM, MXR at the lower level
    for (int i = 0; i < 512; i++) begin
      logic [7:0] f;
      logic [9:0] v1, v0;
      logic [11:0] off;
      logic [21:0] lp;
      logic [1:0] e;
      string tag;
      f   = {1'b1, 1'b1, 1'b0, i[3], i[2], i[1], i[0], 1'b1};
      v1  = 10'(i * 37 + 3);
      v0  = 10'(i * 11 + 5);
      off = 12'(i * 13);
      lp  = 22'(i * 977 + 32'h1234);
      set_pte(2'd1, v1, {22'd2, 10'h001});
      set_pte(2'd2, v0, {lp, 2'b11, f});
      walk({v1, v0, off}, 2'(i >> 4), i[6], i[7], i[8], 22'd1);
      e = exp_flt(f, 2'(i >> 4), i[6], i[7], i[8], 1'b0, 1'b0, 1'b1);
      if (!f[1] && f[2]) tag = "R3 reserved encoding";
      else if (!f[1] && !f[3]) tag = "R4 pointer at lower level";
      else tag = "R5 permission";
      for (int g = 0; g < 2; g++) begin
        chk(g_flt[g] == e, tag, 34'(g_flt[g]), 34'(e));
        if (e == 2'd0) begin
          chk(g_pa[g] == {lp, off}, "R7 lower-level address", g_pa[g], {lp, off});
          chk(!g_mg[g], "R7 lower-level flag", 34'(g_mg[g]), 34'd0);
        end
        chk(wr_cnt[g] == 0, "R8 no write when bits set", 34'(wr_cnt[g]), 34'd0);
        chk(rd_a[g] == {22'd1, v1, 2'b00}, "R2 first entry address", rd_a[g], {22'd1, v1, 2'b00});
        chk(rd_b[g] == {22'd2, v0, 2'b00}, "R2 second entry address", rd_b[g], {22'd2, v0, 2'b00});
      end
    end

    // R8 R9: accessed/dirty handling in both modes
    for (int i = 0; i < 16; i++) begin
      logic [7:0] f;
      logic [31:0] pte, expw;
      logic need;
      logic [1:0] acc;
      acc  = 2'(i);
      f    = {i[3], i[2], 6'b001111};
      pte  = {22'h2ABCD, 2'b10, f};
      need = !i[2] || (acc[1] && !i[3]);
      expw = pte | 32'h40 | (acc[1] ? 32'h80 : 32'h0);
      set_pte(2'd1, 10'd7, {22'd2, 10'h001});
      set_pte(2'd2, 10'd9, pte);
      walk({10'd7, 10'd9, 12'h321}, acc, 1'b0, 1'b0, 1'b0, 22'd1);
      chk(g_flt[0] == 2'd0, "R8 update mode succeeds", 34'(g_flt[0]), 34'd0);
      chk(g_pa[0] == {22'h2ABCD, 12'h321}, "R8 address after update", g_pa[0], {22'h2ABCD, 12'h321});
      chk(wr_cnt[0] == (need ? 1 : 0), "R8 write count", 34'(wr_cnt[0]), 34'(need));
      chk(mem[0][{2'd2, 10'd9}] == (need ? expw : pte), "R8 written entry",
          34'(mem[0][{2'd2, 10'd9}]), 34'(need ? expw : pte));
      chk(lock_bad[0] == 0, "R8 lock held on write", 34'(lock_bad[0]), 34'd0);
      chk(g_flt[1] == (need ? 2'd1 : 2'd0), "R9 fault instead of update", 34'(g_flt[1]), 34'(need));
      chk(wr_cnt[1] == 0, "R9 no write", 34'(wr_cnt[1]), 34'd0);
    end

    // R6 R7: upper-level leaves, aligned and misaligned
    for (int i = 0; i < 20; i++) begin
      logic [21:0] lp;
      logic [9:0] v1;
      logic [21:0] low;
      logic mis;
      mis = (i >= 10);
      v1  = 10'(i * 53 + 1);
      low = 22'(i * 12345);
      lp  = {12'(i * 91 + 7), mis ? 10'(1 << (i - 10)) : 10'd0};
      set_pte(2'd1, v1, {lp, 2'b00, 8'hCF});
      walk({v1, low}, 2'd1, 1'b0, 1'b0, 1'b0, 22'd1);
      for (int g = 0; g < 2; g++) begin
        chk(g_flt[g] == (mis ? 2'd1 : 2'd0), mis ? "R6 misaligned large page" : "R7 large page",
            34'(g_flt[g]), 34'(mis));
        chk(rd_cnt[g] == 1, "R7 single read for upper leaf", 34'(rd_cnt[g]), 34'd1);
        if (!mis) begin
          chk(g_pa[g] == {lp[21:10], low}, "R7 large page address", g_pa[g], {lp[21:10], low});
          chk(g_mg[g], "R7 large page flag", 34'(g_mg[g]), 34'd1);
        end
      end
    end

    // R3: invalid and reserved at the upper level stop the walk
    for (int i = 0; i < 2; i++) begin
      set_pte(2'd1, 10'd100, i == 0 ? {22'd2, 10'h000} : {22'd2, 10'h005});
      walk({10'd100, 22'h0}, 2'd1, 1'b0, 1'b0, 1'b0, 22'd1);
      for (int g = 0; g < 2; g++) begin
        chk(g_flt[g] == 2'd1, "R3 upper invalid", 34'(g_flt[g]), 34'd1);
        chk(rd_cnt[g] == 1, "R3 no further read", 34'(rd_cnt[g]), 34'd1);
      end
    end

    // R10: access errors on first read, second read, and write
    walk({10'd3, 22'h0}, 2'd0, 1'b0, 1'b0, 1'b0, 22'h10);
    for (int g = 0; g < 2; g++)
      chk(g_flt[g] == 2'd2, "R10 root read error", 34'(g_flt[g]), 34'd2);
    set_pte(2'd1, 10'd4, {22'h20, 10'h001});
    walk({10'd4, 22'h0}, 2'd1, 1'b0, 1'b0, 1'b0, 22'd1);
    for (int g = 0; g < 2; g++)
      chk(g_flt[g] == 2'd2, "R10 second read error", 34'(g_flt[g]), 34'd2);
    set_pte(2'd1, 10'd5, {22'd3, 10'h001});
    set_pte(2'd3, 10'd6, {22'h155, 10'h00F});
    walk({10'd5, 10'd6, 12'h0}, 2'd2, 1'b0, 1'b0, 1'b0, 22'd1);
    chk(g_flt[0] == 2'd2, "R10 write error", 34'(g_flt[0]), 34'd2);
    chk(g_flt[1] == 2'd1, "R9 fault mode on same entry", 34'(g_flt[1]), 34'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule